// File: doc/BRIEF.md
# Sprite Pixel Mixer with Colour Palette

This block is the last stage of a tile-based pixel pipeline. On every pixel it receives a 3-bit colour index and a 3-bit palette select from each foreground sprite slot, and one more pair from the background layer. All of these arrive already aligned with the pixel. The block picks one winning pixel by fixed slot priority. It then forms a 6-bit palette address from the winner, reads a 12-bit RGB colour from a writable palette store, and registers that colour onto the output.

A sprite slot takes part only when its colour index is non-zero. The lowest-numbered such slot wins. Sprites always cover the background, and there is no per-sprite priority control. The background is used only when every sprite slot is transparent. Palette entries are loaded through a plain write-enable, address and data port that can be used at any time. A blanking input and a pixel-valid input both force the registered output to black.

Top module: `spr_pixel_mixer`

## Requirements
- R1: After a synchronous active-low reset, `rgb_out` is 0 and every palette entry holds 0, so any pixel shown before the first write comes out as 0.
- R2: When `pal_we` is high at a rising edge, `pal_wdata` is stored in the entry at `pal_addr`. The address is {palette select in bits 5:3, colour index in bits 2:0}.
- R3: Of all sprite slots with a non-zero colour index, the lowest-numbered one supplies both the palette select and the colour index. Slot k uses bits [3k+2:3k] of `spr_cidx` and of `spr_psel`.
- R4: A sprite slot whose colour index is 0 is transparent and has no effect on the output, whatever its palette select.
- R5: When every sprite slot is transparent, the entry {`bg_psel`, `bg_cidx`} is shown. A background colour index of 0 is a valid opaque colour.
- R6: Any non-transparent sprite wins over the background, whatever the background values are.
- R7: When `blank` is high on a valid pixel, `rgb_out` is 0 after the next edge.
- R8: When `pix_valid` is low, `rgb_out` is 0 after the next edge.
- R9: `rgb_out` shows the colour of the pixel presented at the previous rising edge. It holds that colour until the next edge.
- R10: A palette write and a pixel read of the same entry can happen in the same cycle. In that case the pixel shows the entry's old colour, and the next pixel shows the new one.
- R11: The colour is output exactly as stored: red in bits 11:8, green in bits 7:4, blue in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel pipeline clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Inputs carry a pixel this cycle |
| blank | input | 1 | Pixel lies in the blanking interval |
| spr_cidx | input | 3*N_SPR | Colour index per sprite slot, slot k at [3k+2:3k] |
| spr_psel | input | 3*N_SPR | Palette select per sprite slot, slot k at [3k+2:3k] |
| bg_cidx | input | 3 | Background colour index |
| bg_psel | input | 3 | Background palette select |
| pal_we | input | 1 | Palette write strobe |
| pal_addr | input | 6 | Palette entry to write, {select, index} |
| pal_wdata | input | 12 | Colour to write |
| rgb_out | output | 12 | Registered 4:4:4 colour |

## Verification
A palette write and a pixel lookup can fall in the same cycle and target the same entry. The bench provokes this by presenting a background pixel whose address equals `pal_addr` while `pal_wdata` carries a new colour. It then requires the old colour on that pixel and the new colour on the next pixel at the same address. The priority pick and the blanking override can also coincide. The bench drives opaque sprites with `blank` high and requires black; it also sweeps every index pattern of a four-slot configuration against an arithmetically computed winner.

// File: rtl/spr_mix_pkg.sv
// Package: widths and types shared by the sprite pixel mixer.
// Assumes the 8 palettes x 8 colours x 12-bit organisation.
package spr_mix_pkg;
    localparam int CIDX_W     = 3;
    localparam int PSEL_W     = 3;
    localparam int COLOR_W    = 12;
    localparam int PAL_ADDR_W = PSEL_W + CIDX_W;
    localparam int PAL_DEPTH  = 1 << PAL_ADDR_W;

    typedef logic [COLOR_W-1:0] rgb_t;

    typedef struct packed {
        logic [PSEL_W-1:0] psel;
        logic [CIDX_W-1:0] cidx;
    } pix_sel_t;
endpackage

// File: rtl/spr_first_opaque.sv
// Module: finds the lowest-numbered sprite slot with a non-zero colour
// index and returns its {palette, index} pair.
// Assumes slot k occupies bits [3k+2:3k] of both flat input vectors.
// The logic is purely combinational.
module spr_first_opaque
    import spr_mix_pkg::*;
#(
    parameter int N_SPR = 128
) (
    input  logic [N_SPR*CIDX_W-1:0] spr_cidx,
    input  logic [N_SPR*PSEL_W-1:0] spr_psel,
    output logic                    hit,
    output logic [N_SPR-1:0]        win_oh,
    output pix_sel_t                win_sel
);
    logic [N_SPR-1:0] opaque;
    logic [N_SPR:0]   seen;

    assign seen[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < N_SPR; k++) begin : g_slot
            // Slot is opaque when its colour index is non-zero.
            assign opaque[k]  = |spr_cidx[k*CIDX_W +: CIDX_W];
            // Running flag: some lower slot is already opaque.
            assign seen[k+1]  = seen[k] | opaque[k];
            // Winner is opaque with no opaque slot below it.
            assign win_oh[k]  = opaque[k] & ~seen[k];
        end
    endgenerate

    assign hit = seen[N_SPR];

    // AND-OR mux of the winning slot's pair driven by the one-hot vector.
    always_comb begin
        win_sel = '0;
        for (int i = 0; i < N_SPR; i++) begin
            if (win_oh[i]) begin
                win_sel.psel = win_sel.psel | spr_psel[i*PSEL_W +: PSEL_W];
                win_sel.cidx = win_sel.cidx | spr_cidx[i*CIDX_W +: CIDX_W];
            end
        end
    end
endmodule

// File: rtl/spr_pal_store.sv
// Module: palette store with one write port and one combinational read port.
// Assumes the read happens in the same cycle as the address. A write lands
// at the edge, so a read in the write cycle returns the old value.
module spr_pal_store
    import spr_mix_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [PAL_ADDR_W-1:0] waddr,
    input  rgb_t                  wdata,
    input  logic [PAL_ADDR_W-1:0] raddr,
    output rgb_t                  rdata
);
    rgb_t mem [PAL_DEPTH];

    genvar e;
    generate
        for (e = 0; e < PAL_DEPTH; e++) begin : g_ent
            // Entry register: cleared on reset, loaded when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[e] <= '0;
                else if (we && (waddr == PAL_ADDR_W'(e)))
                    mem[e] <= wdata;
            end
        end
    endgenerate

    assign rdata = mem[raddr];
endmodule

// File: rtl/spr_rgb_out.sv
// Module: output register for the looked-up colour.
// Assumes the show flag already combines pixel-valid with not-blank.
module spr_rgb_out
    import spr_mix_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic show,
    input  rgb_t color_in,
    output rgb_t rgb_out
);
    // Registers the colour, or black when the pixel is not shown.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rgb_out <= '0;
        else
            rgb_out <= show ? color_in : '0;
    end
endmodule

// File: rtl/spr_pixel_mixer.sv
// Module: top of the sprite pixel mixer. Chooses the winning pixel among
// the sprite slots and the background, looks up its colour in the palette,
// and registers the result. The latency is one cycle.
// Assumes all pixel inputs are aligned to the same pixel.
module spr_pixel_mixer
    import spr_mix_pkg::*;
#(
    parameter int N_SPR = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pix_valid,
    input  logic                    blank,
    input  logic [N_SPR*CIDX_W-1:0] spr_cidx,
    input  logic [N_SPR*PSEL_W-1:0] spr_psel,
    input  logic [CIDX_W-1:0]       bg_cidx,
    input  logic [PSEL_W-1:0]       bg_psel,
    input  logic                    pal_we,
    input  logic [PAL_ADDR_W-1:0]   pal_addr,
    input  logic [COLOR_W-1:0]      pal_wdata,
    output logic [COLOR_W-1:0]      rgb_out
);
    logic             hit;
    logic [N_SPR-1:0] win_oh;
    pix_sel_t         spr_sel;
    pix_sel_t         bg_sel;
    pix_sel_t         final_sel;
    rgb_t             color;

    spr_first_opaque #(.N_SPR(N_SPR)) u_pick (
        .spr_cidx (spr_cidx),
        .spr_psel (spr_psel),
        .hit      (hit),
        .win_oh   (win_oh),
        .win_sel  (spr_sel)
    );

    // Background pair, used when no sprite is opaque.
    always_comb begin
        bg_sel.psel = bg_psel;
        bg_sel.cidx = bg_cidx;
    end

    // Sprites always cover the background.
    assign final_sel = hit ? spr_sel : bg_sel;

    spr_pal_store u_pal (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pal_we),
        .waddr (pal_addr),
        .wdata (pal_wdata),
        .raddr (final_sel),
        .rdata (color)
    );

    spr_rgb_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .show     (pix_valid & ~blank),
        .color_in (color),
        .rgb_out  (rgb_out)
    );
endmodule

// File: rtl/spr_mix_checker.sv
// Module: assertion checker bound to spr_pixel_mixer. It watches the ports
// and the pick result.
module spr_mix_checker
    import spr_mix_pkg::*;
#(
    parameter int N_SPR = 128
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pix_valid,
    input logic                    blank,
    input logic [N_SPR*CIDX_W-1:0] spr_cidx,
    input logic                    hit,
    input logic [N_SPR-1:0]        win_oh,
    input logic [COLOR_W-1:0]      rgb_out
);
    logic [N_SPR-1:0] nz;

    // Non-zero-index flags seen from the ports.
    always_comb begin
        for (int i = 0; i < N_SPR; i++)
            nz[i] = |spr_cidx[i*CIDX_W +: CIDX_W];
    end

    // R7: blanking yields black.
    a_r7_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (rgb_out == '0));

    // R8: no valid pixel yields black.
    a_r8_invalid_black: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (rgb_out == '0));

    // R3: at most one winner, and only when some sprite is opaque.
    a_r3_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_oh) && (hit == (|nz)) && ((win_oh != '0) == hit));

    // R4: the winner is never a transparent slot.
    a_r4_winner_opaque: assert property (@(posedge clk) disable iff (!rst_n)
        (win_oh & ~nz) == '0);

    // R3: no opaque slot lies below the winner.
    a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (((win_oh - N_SPR'(1)) & nz) == '0));
endmodule

bind spr_pixel_mixer spr_mix_checker #(.N_SPR(N_SPR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .blank     (blank),
    .spr_cidx  (spr_cidx),
    .hit       (hit),
    .win_oh    (win_oh),
    .rgb_out   (rgb_out)
);

// File: tb/spr_pixel_mixer_test.sv
// Bench: four-slot configuration. Sweeps every sprite index pattern,
// plus reset, blanking, validity, latency and write/read collision cases.
module spr_pixel_mixer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_valid = 1'b0;
    logic          blank = 1'b0;
    logic [NS*3-1:0] spr_cidx = '0;
    logic [NS*3-1:0] spr_psel = '0;
    logic [2:0]    bg_cidx = '0;
    logic [2:0]    bg_psel = '0;
    logic          pal_we = 1'b0;
    logic [5:0]    pal_addr = '0;
    logic [11:0]   pal_wdata = '0;
    logic [11:0]   rgb_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spr_pixel_mixer #(.N_SPR(NS)) uut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .blank(blank),
        .spr_cidx(spr_cidx), .spr_psel(spr_psel), .bg_cidx(bg_cidx),
        .bg_psel(bg_psel), .pal_we(pal_we), .pal_addr(pal_addr),
        .pal_wdata(pal_wdata), .rgb_out(rgb_out)
    );

    function automatic logic [11:0] pal_val(input int a);
        return 12'((a * 37 + 5) & 12'hFFF);
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: rgb_out actual %h expected %h", req, act, exp);
        end
    endtask

    // One pixel: drive at a falling edge, check after the next rising edge.
    task automatic pixel(input string req, input logic [11:0] exp);
        @(negedge clk);
        check(req, rgb_out, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset output", rgb_out, 12'h000);
        rst_n = 1'b1;

        // R1: palette cleared, an opaque background pixel reads 0.
        pix_valid = 1'b1; bg_psel = 3'd5; bg_cidx = 3'd3;
        pixel("R1 cleared palette", 12'h000);
        spr_cidx = 12'h001; spr_psel = 12'h007;
        pixel("R1 cleared palette sprite", 12'h000);
        spr_cidx = '0; pix_valid = 1'b0;

        // R2: load every entry with a distinct colour.
        for (int a = 0; a < 64; a++) begin
            pal_we = 1'b1; pal_addr = 6'(a); pal_wdata = pal_val(a);
            @(negedge clk);
        end
        pal_we = 1'b0;

        // R2/R5/R11: read back every entry through the background path.
        pix_valid = 1'b1;
        for (int a = 0; a < 64; a++) begin
            bg_psel = 3'(a >> 3); bg_cidx = 3'(a);
            pixel("R2 R5 R11 entry readback", pal_val(a));
        end

        // R3/R4/R6/R5: all index patterns for four slots.
        for (int v = 0; v < 4096; v++) begin
            int win;
            int exp_a;
            win = -1;
            for (int k = 0; k < NS; k++) begin
                spr_cidx[k*3 +: 3] = 3'(v >> (3*k));
                spr_psel[k*3 +: 3] = 3'(k + (v >> 2));
            end
            bg_psel = 3'(v) ^ 3'd5;
            bg_cidx = 3'(v >> 5);
            for (int k = NS - 1; k >= 0; k--)
                if (((v >> (3*k)) & 7) != 0) win = k;
            if (win >= 0) begin
                exp_a = (((win + (v >> 2)) & 7) << 3) | ((v >> (3*win)) & 7);
                pixel("R3 R4 R6 sprite winner", pal_val(exp_a));
            end else begin
                exp_a = ((((v & 7) ^ 5) & 7) << 3) | ((v >> 5) & 7);
                pixel("R5 background fallback", pal_val(exp_a));
            end
        end

        // R4: a transparent slot with any palette select has no effect.
        spr_cidx = {3'd0, 3'd0, 3'd0, 3'd0}; spr_psel = 12'hFFF;
        bg_psel = 3'd2; bg_cidx = 3'd0;
        pixel("R4 transparent ignored", pal_val(16));

        // R7: blanking with an opaque sprite gives black.
        spr_cidx = 12'h00A; spr_psel = 12'h003; blank = 1'b1;
        pixel("R7 blank forces black", 12'h000);
        blank = 1'b0;
        pixel("R7 after blank", pal_val((3 << 3) | 2));

        // R8: an invalid pixel gives black.
        pix_valid = 1'b0;
        pixel("R8 invalid forces black", 12'h000);
        pix_valid = 1'b1;

        // R9: the output changes only at the edge after the pixel.
        spr_cidx = '0; bg_psel = 3'd7; bg_cidx = 3'd7;
        pixel("R9 first pixel", pal_val(63));
        bg_psel = 3'd1; bg_cidx = 3'd1;
        #1;
        check("R9 holds until edge", rgb_out, pal_val(63));
        @(negedge clk);
        check("R9 next pixel", rgb_out, pal_val(9));

        // R10: write and read of the same entry in one cycle.
        bg_psel = 3'd4; bg_cidx = 3'd6;
        pal_we = 1'b1; pal_addr = 6'd38; pal_wdata = 12'hABC;
        pixel("R10 old colour on collision", pal_val(38));
        pal_we = 1'b0;
        pixel("R10 new colour after write", 12'hABC);

        pix_valid = 1'b0;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule